// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block sits beside the output-frequency selector of a programmable clock generator and protects the system against a frequency change that leaves it unable to run. Whenever software asks for a new frequency while the watchdog is enabled, a down-counter is loaded from a programmable time-out. The counter then counts time-base ticks. Software proves that the system survived the change by clearing the enable bit before the count runs out.

If the count does run out, the block does four things. It sets a sticky status flag. It puts back the frequency selection that was active before the change. It locks itself so that later frequency requests are ignored. If enabled, it sends a fixed-width reset pulse to the system. The lock is released only by clearing the enable bit. A separate enable produces the same reset pulse after every accepted frequency change.

Software reaches the block through two byte-wide registers with write and read strobes. Three drive-strength flags are held in one register and brought out unchanged for the clock output stages.

Top module: `fchg_watchdog`

## Requirements
- R1: After reset, the time-out register reads 0x3E and the control register reads 0x00. `sys_rst_o` is low and `freq_sel_o` equals the `FSEL_RST` parameter (default 0).
- R2: Time-out register layout (`reg_addr_i`=0): bits 5:1 hold the count field N and bit 0 selects the unit (0 = `tick_short_i`, 1 = `tick_long_i`). Bits 7:6 always read 0. A read strobe returns the register value on `reg_rdata_o` one cycle later.
- R3: Control register layout (`reg_addr_i`=1): bits 7:5 are drive flags and appear on `drv_o[2:0]`. Bit 4 enables a reset on time-out, bit 3 enables a reset on frequency change, bit 2 is the time-out status and bit 1 is the watchdog enable. Bit 0 always reads 0.
- R4: While the block is not locked, a `freq_req_i` pulse is accepted and `freq_sel_o` takes `freq_sel_i` on the next cycle.
- R5: With the enable bit set, an accepted change arms the counter with N+1 units. The time-out happens on the (N+1)-th tick of the selected unit, and ticks of the other unit have no effect.
- R6: On time-out, the status bit becomes 1, `freq_sel_o` returns to the selection that was active just before the arming change, and the block locks.
- R7: While locked, frequency requests are ignored: `freq_sel_o` does not change and no reset pulse is caused.
- R8: Writing the enable bit to 0 stops a running count without a time-out and releases the lock. A later arming reloads the count from the field.
- R9: Writing 1 to status bit 2 clears it. Writing 0 leaves it unchanged.
- R10: A time-out with control bit 4 set drives `sys_rst_o` high for exactly 4 cycles. With bit 4 clear, no pulse is produced.
- R11: An accepted change with control bit 3 set drives `sys_rst_o` high for exactly 4 cycles.
- R12: A reset request that arrives while a pulse is running neither extends nor repeats it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | Register select: 0 time-out, 1 control |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| tick_short_i | input | 1 | Short time-base tick, one cycle wide |
| tick_long_i | input | 1 | Long time-base tick, one cycle wide |
| freq_req_i | input | 1 | Frequency change request strobe |
| freq_sel_i | input | FSEL_W | Requested frequency selection |
| freq_sel_o | output | FSEL_W | Active frequency selection |
| drv_o | output | 3 | Stored drive-strength flags |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions check on every cycle that:
- status stays set until a write-one clears it,
- a time-out always leaves the block flagged and locked,
- a locked block holds its selection,
- clearing the enable releases the lock,
- reserved bits read as zero,
- every reset pulse is exactly four cycles long.

Some properties can only be shown by the bench scenarios, which compare the block on every clock against a behavioural model:
- the count is exact to N+1 ticks of the selected unit,
- the value that is restored is the selection from before the arming change,
- a stopped count restarts from the full field,
- a request that arrives during a pulse is absorbed.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W   = 8;
  localparam int TMO_W   = 5;
  localparam int NUM_DRV = 3;

  typedef enum logic {
    REG_TMO = 1'b0,
    REG_CTL = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic [1:0]       rsvd;
    logic [TMO_W-1:0] count;
    logic             unit_long;
  } tmo_reg_t;

  typedef struct packed {
    logic [NUM_DRV-1:0] drv;
    logic               rst_on_tmo;
    logic               rst_on_chg;
    logic               status;
    logic               wd_en;
    logic               rsvd;
  } ctl_reg_t;
endpackage

// File: rtl/fwd_regs.sv
module fwd_regs
  import fwd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             timeout_i,
  output tmo_reg_t         tmo_o,
  output ctl_reg_t         ctl_o,
  output logic [REG_W-1:0] rdata_o
);
  tmo_reg_t         tmo_q;
  ctl_reg_t         ctl_q;
  logic [REG_W-1:0] rdata_q;
  tmo_reg_t         wr_tmo;
  ctl_reg_t         wr_ctl;
  logic             wr_tmo_en, wr_ctl_en;
  logic             unused_rsvd;

  assign wr_tmo      = tmo_reg_t'(wdata_i);
  assign wr_ctl      = ctl_reg_t'(wdata_i);
  assign wr_tmo_en   = wr_i && (reg_addr_e'(addr_i) == REG_TMO);
  assign wr_ctl_en   = wr_i && (reg_addr_e'(addr_i) == REG_CTL);
  assign unused_rsvd = ^{wr_tmo.rsvd, wr_ctl.rsvd};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q <= '{rsvd: 2'b00, count: '1, unit_long: 1'b0};
    end else if (wr_tmo_en) begin
      tmo_q.count     <= wr_tmo.count;
      tmo_q.unit_long <= wr_tmo.unit_long;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl_en) begin
        ctl_q.drv        <= wr_ctl.drv;
        ctl_q.rst_on_tmo <= wr_ctl.rst_on_tmo;
        ctl_q.rst_on_chg <= wr_ctl.rst_on_chg;
        ctl_q.wd_en      <= wr_ctl.wd_en;
      end
      // time-out set wins over a same-cycle write-one clear
      if (timeout_i)                       ctl_q.status <= 1'b1;
      else if (wr_ctl_en && wr_ctl.status) ctl_q.status <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= (reg_addr_e'(addr_i) == REG_CTL) ? REG_W'(ctl_q) : REG_W'(tmo_q);
  end

  assign tmo_o   = tmo_q;
  assign ctl_o   = ctl_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fwd_timer.sv
module fwd_timer #(
  parameter int TMO_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             arm_i,
  input  logic             unit_long_i,
  input  logic             tick_short_i,
  input  logic             tick_long_i,
  input  logic [TMO_W-1:0] count_i,
  output logic             timeout_o
);
  localparam int CNT_W = TMO_W + 1;

  logic [CNT_W-1:0] cnt_q, reload;
  logic             run_q, unit_tick, last_unit;

  assign reload    = CNT_W'(count_i) + CNT_W'(1);
  assign unit_tick = unit_long_i ? tick_long_i : tick_short_i;
  assign last_unit = (cnt_q == CNT_W'(1));
  // re-arm in the same cycle as the final tick restarts instead of firing
  assign timeout_o = en_i && run_q && unit_tick && last_unit && !arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= reload;
      run_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= reload;
      run_q <= 1'b1;
    end else if (run_q && unit_tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (last_unit) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fwd_freq_ctl.sv
module fwd_freq_ctl #(
  parameter int              FSEL_W   = 3,
  parameter logic [FSEL_W-1:0] FSEL_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic [FSEL_W-1:0] sel_i,
  input  logic              timeout_i,
  output logic [FSEL_W-1:0] sel_o,
  output logic              locked_o,
  output logic              accept_o,
  output logic              arm_o
);
  logic [FSEL_W-1:0] sel_q, rec_q;
  logic              locked_q;

  assign accept_o = req_i && !locked_q;
  assign arm_o    = accept_o && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= FSEL_RST;
      rec_q    <= FSEL_RST;
      locked_q <= 1'b0;
    end else begin
      if (timeout_i)     sel_q <= rec_q;
      else if (accept_o) sel_q <= sel_i;
      // recovery point is the selection in force before the arming change
      if (arm_o) rec_q <= sel_q;
      if (!en_i)          locked_q <= 1'b0;
      else if (timeout_i) locked_q <= 1'b1;
    end
  end

  assign sel_o    = sel_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/fwd_rst_pulse.sv
module fwd_rst_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PC_W = $clog2(PULSE_CYC + 1);

  logic [PC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (cnt_q != PC_W'(0))  cnt_q <= cnt_q - PC_W'(1);
    else if (trig_i)             cnt_q <= PC_W'(PULSE_CYC);
  end

  assign pulse_o = (cnt_q != PC_W'(0));
endmodule

// File: rtl/fchg_watchdog.sv
module fchg_watchdog
  import fwd_pkg::*;
#(
  parameter int                FSEL_W     = 3,
  parameter logic [FSEL_W-1:0] FSEL_RST   = '0,
  parameter int                RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tick_short_i,
  input  logic              tick_long_i,
  input  logic              freq_req_i,
  input  logic [FSEL_W-1:0] freq_sel_i,
  output logic [FSEL_W-1:0] freq_sel_o,
  output logic [NUM_DRV-1:0] drv_o,
  output logic              sys_rst_o
);
  tmo_reg_t tmo_w;
  ctl_reg_t ctl_w;
  logic     timeout_w, locked_w, accept_w, arm_w, rst_trig_w;

  fwd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .timeout_i (timeout_w),
    .tmo_o     (tmo_w),
    .ctl_o     (ctl_w),
    .rdata_o   (reg_rdata_o)
  );

  fwd_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctl_w.wd_en),
    .arm_i        (arm_w),
    .unit_long_i  (tmo_w.unit_long),
    .tick_short_i (tick_short_i),
    .tick_long_i  (tick_long_i),
    .count_i      (tmo_w.count),
    .timeout_o    (timeout_w)
  );

  fwd_freq_ctl #(.FSEL_W(FSEL_W), .FSEL_RST(FSEL_RST)) u_freq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctl_w.wd_en),
    .req_i     (freq_req_i),
    .sel_i     (freq_sel_i),
    .timeout_i (timeout_w),
    .sel_o     (freq_sel_o),
    .locked_o  (locked_w),
    .accept_o  (accept_w),
    .arm_o     (arm_w)
  );

  assign rst_trig_w = (timeout_w && ctl_w.rst_on_tmo) || (accept_w && ctl_w.rst_on_chg);

  fwd_rst_pulse #(.PULSE_CYC(RST_CYCLES)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (rst_trig_w),
    .pulse_o (sys_rst_o)
  );

  assign drv_o = ctl_w.drv;
endmodule

// File: rtl/fchg_watchdog_chk.sv
module fchg_watchdog_chk #(
  parameter int FSEL_W     = 3,
  parameter int RST_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic              reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic [FSEL_W-1:0] freq_sel_o,
  input logic              sys_rst_o,
  input logic              timeout_i,
  input logic              locked_i,
  input logic              status_i,
  input logic              en_i
);
  localparam int HR_W = $clog2(RST_CYCLES + 2) + 1;

  logic [HR_W-1:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= '0;
    else if (sys_rst_o) hi_run <= hi_run + HR_W'(1);
    else                hi_run <= '0;
  end

  p_rsvd_tmo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_addr_i) |=> (reg_rdata_o[7:6] == 2'b00));

  p_rsvd_ctl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i) |=> !reg_rdata_o[0]);

  p_timeout_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> (status_i && locked_i));

  p_locked_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(freq_sel_o));

  p_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !locked_i);

  p_status_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i && !(reg_wr_i && reg_addr_i && reg_wdata_i[2])) |=> status_i);

  p_pulse_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (hi_run == HR_W'(RST_CYCLES)));

  p_pulse_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (hi_run < HR_W'(RST_CYCLES)));
endmodule

bind fchg_watchdog fchg_watchdog_chk #(.FSEL_W(FSEL_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .freq_sel_o  (freq_sel_o),
  .sys_rst_o   (sys_rst_o),
  .timeout_i   (timeout_w),
  .locked_i    (locked_w),
  .status_i    (ctl_w.status),
  .en_i        (ctl_w.wd_en)
);

// File: tb/fchg_watchdog_tb.sv
module fchg_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          tks = 1'b0, tkl = 1'b0, req = 1'b0;
  logic [FW-1:0] sel_in = '0;
  logic [FW-1:0] sel_out;
  logic [2:0]    drv;
  logic          srst;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fchg_watchdog u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tick_short_i(tks), .tick_long_i(tkl),
    .freq_req_i(req), .freq_sel_i(sel_in), .freq_sel_o(sel_out),
    .drv_o(drv), .sys_rst_o(srst)
  );

  // behavioural reference
  int         m_tmo, m_pre, m_drv, m_rwd, m_rfc, m_st, m_en;
  int         m_sel, m_rec, m_locked, m_run, m_cnt, m_left, m_rdata;
  int         t_acc, t_arm, t_to, t_tick, t_trig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmo = 31; m_pre = 0; m_drv = 0; m_rwd = 0; m_rfc = 0; m_st = 0; m_en = 0;
      m_sel = 0; m_rec = 0; m_locked = 0; m_run = 0; m_cnt = 0; m_left = 0; m_rdata = 0;
    end else begin
      t_acc  = (req && !m_locked) ? 1 : 0;
      t_arm  = (t_acc && m_en) ? 1 : 0;
      t_tick = m_pre ? int'(tkl) : int'(tks);
      t_to   = (m_en && m_run && t_tick && m_cnt == 1 && !t_arm) ? 1 : 0;
      t_trig = ((t_to && m_rwd) || (t_acc && m_rfc)) ? 1 : 0;
      if (rd) m_rdata = addr ? ((m_drv << 5) | (m_rwd << 4) | (m_rfc << 3) | (m_st << 2) | (m_en << 1))
                             : ((m_tmo << 1) | m_pre);
      if (m_left > 0) m_left--;
      else if (t_trig) m_left = 4;
      if (!m_en) m_run = 0;
      else if (t_arm) begin m_run = 1; m_cnt = m_tmo + 1; end
      else if (m_run && t_tick) begin
        if (m_cnt == 1) m_run = 0;
        m_cnt--;
      end
      if (!m_en) m_locked = 0; else if (t_to) m_locked = 1;
      if (t_arm) m_rec = m_sel;
      if (t_to) m_sel = m_rec; else if (t_acc) m_sel = int'(sel_in);
      if (t_to) m_st = 1; else if (wr && addr && wdata[2]) m_st = 0;
      if (wr && !addr) begin m_tmo = int'(wdata[5:1]); m_pre = int'(wdata[0]); end
      if (wr && addr) begin
        m_drv = int'(wdata[7:5]); m_rwd = int'(wdata[4]); m_rfc = int'(wdata[3]); m_en = int'(wdata[1]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 model freq_sel_o", int'(sel_out), m_sel);
      chk("R10 model sys_rst_o", int'(srst), (m_left > 0) ? 1 : 0);
      chk("R3 model drv_o", int'(drv), m_drv);
      chk("R2 model reg_rdata_o", int'(rdata), m_rdata);
    end
  end

  task automatic reg_write(logic a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(logic a, int exp, string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic freq(int v);
    @(negedge clk); req = 1'b1; sel_in = FW'(v);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic tick(bit long_unit, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (long_unit) tkl = 1'b1; else tks = 1'b1;
      @(negedge clk); tkl = 1'b0; tks = 1'b0;
    end
  endtask

  task automatic count_high(int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      if (srst) hi++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung run expected completion");
    finish_run();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 freq_sel_o reset", int'(sel_out), 0);
    chk("R1 sys_rst_o reset", int'(srst), 0);
    reg_read(1'b0, 8'h3E, "R1 tmo reg reset");
    reg_read(1'b1, 8'h00, "R1 ctl reg reset");
    // R2 layout and reserved bits
    reg_write(1'b0, 8'hFF);
    reg_read(1'b0, 8'h3F, "R2 tmo reserved read 0");
    reg_write(1'b0, 8'h04);
    reg_read(1'b0, 8'h04, "R2 tmo field");
    // R3 control layout
    reg_write(1'b1, 8'hE1);
    chk("R3 drv_o", int'(drv), 7);
    reg_read(1'b1, 8'hE0, "R3 ctl reserved read 0");
    reg_write(1'b1, 8'h00);
    // R4 plain change
    freq(5);
    chk("R4 change accepted", int'(sel_out), 5);
    // R5/R6 timeout on third short tick, long ticks ignored
    reg_write(1'b1, 8'h02);
    freq(6);
    tick(1'b1, 3);
    chk("R5 other unit ignored", int'(sel_out), 6);
    tick(1'b0, 2);
    chk("R5 not yet expired", int'(sel_out), 6);
    tick(1'b0, 1);
    chk("R6 recovery restored", int'(sel_out), 5);
    chk("R10 no pulse when disabled", int'(srst), 0);
    reg_read(1'b1, 8'h06, "R6 status set");
    // R7 locked
    freq(7);
    chk("R7 request ignored", int'(sel_out), 5);
    chk("R7 no pulse", int'(srst), 0);
    // R9 status clear semantics
    reg_write(1'b1, 8'h02);
    reg_read(1'b1, 8'h06, "R9 write 0 keeps status");
    reg_write(1'b1, 8'h06);
    reg_read(1'b1, 8'h02, "R9 write 1 clears status");
    freq(1);
    chk("R7 still locked", int'(sel_out), 5);
    // R8 unlock and stop
    reg_write(1'b1, 8'h00);
    freq(4);
    chk("R8 unlocked", int'(sel_out), 4);
    reg_write(1'b0, 8'h03);
    reg_write(1'b1, 8'h02);
    freq(2);
    tick(1'b1, 1);
    reg_write(1'b1, 8'h00);
    tick(1'b1, 3);
    chk("R8 stopped count", int'(sel_out), 2);
    reg_read(1'b1, 8'h00, "R8 no status after stop");
    reg_write(1'b1, 8'h02);
    freq(3);
    tick(1'b1, 1);
    chk("R8 reloaded count running", int'(sel_out), 3);
    tick(1'b1, 1);
    chk("R5 long unit expiry", int'(sel_out), 2);
    // R10 timeout reset pulse
    reg_write(1'b1, 8'h04);
    reg_write(1'b1, 8'h12);
    reg_write(1'b0, 8'h00);
    freq(1);
    tick(1'b0, 1);
    chk("R6 single-unit expiry", int'(sel_out), 2);
    count_high(8, hi);
    chk("R10 pulse width", hi, 4);
    // R11 change reset pulse
    reg_write(1'b1, 8'h04);
    reg_write(1'b1, 8'h08);
    freq(5);
    chk("R4 change with pulse", int'(sel_out), 5);
    count_high(8, hi);
    chk("R11 pulse width", hi, 4);
    // R12 second request during pulse
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (srst) hi++;
      req    = (i == 0 || i == 2);
      sel_in = (i == 0) ? FW'(6) : FW'(7);
    end
    req = 1'b0;
    chk("R12 no extension", hi, 4);
    chk("R12 second change taken", int'(sel_out), 7);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule